// File: doc/BRIEF.md
# Segmented Address Translator

This block turns a segmented virtual address into a physical address. The top bits of the virtual address pick one entry of a small table held in flip-flops, and the remaining bits form an offset into that segment. Each entry records where the segment starts in physical memory, how long it is, whether it is in use, and which kinds of access (load, store, instruction fetch) it permits. A typical system gives the four entries to code, data, stack and heap.

The lookup is purely combinational, so the result is available in the same cycle as the request. A valid request either yields the physical address (start of the segment plus the offset) or raises a segmentation fault with a cause code. Software fills the table through a synchronous write port, and a write becomes visible at the clock edge that stores it.

Top module: `segx_unit`

## Requirements
- R1: After reset every entry is unused, so any valid request faults with cause code 1 (unused segment) until the entry is written with its in-use bit set.
- R2: The upper SEG_BITS bits of `req_va` select the entry, and the lower VA_W-SEG_BITS bits are the offset.
- R3: A request that does not fault drives `ok` high and `pa` equal to the entry's start address plus the zero-extended offset, modulo 2^PA_W.
- R4: An offset greater than or equal to the entry's length faults with cause code 2 (out of bounds); an offset of length-1 is accepted, a length of 0 rejects every offset, and the largest length 2^(VA_W-SEG_BITS) accepts every offset.
- R5: Access kind 0 (load) needs permission bit 0, kind 1 (store) needs bit 1, kind 2 (fetch) needs bit 2, and kind 3 is never allowed; a missing permission faults with cause code 3.
- R6: When several checks fail, the cause reported is the unused entry first, then out of bounds, then permission.
- R7: A table write takes effect at the clock edge where `wr_en` is sampled high; a request in the same cycle still sees the old entry.
- R8: A write changes only the entry named by `wr_idx`; the other entries keep their contents.
- R9: With `req_valid` low, `ok`, `fault`, `fault_cause` and `pa` are all zero; on a fault, `pa` and `ok` are zero and `fault_cause` is non-zero.
- R10: While `wr_en` is low the table is not changed, whatever values are on the other write inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for table writes |
| rst_n | input | 1 | Asynchronous active-low reset; clears all entries |
| wr_en | input | 1 | Write strobe for the table |
| wr_idx | input | SEG_BITS | Entry to write |
| wr_base | input | PA_W | Physical start address of the segment |
| wr_limit | input | VA_W-SEG_BITS+1 | Segment length in bytes |
| wr_valid | input | 1 | In-use bit for the entry |
| wr_perm | input | 3 | Permissions: bit 0 load, bit 1 store, bit 2 fetch |
| req_valid | input | 1 | A translation request is present |
| req_va | input | VA_W | Virtual address: segment number above offset |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 reserved |
| pa | output | PA_W | Translated physical address, zero when not ok |
| ok | output | 1 | Translation succeeded |
| fault | output | 1 | Segmentation fault |
| fault_cause | output | 2 | 0 none, 1 unused entry, 2 out of bounds, 3 permission |

## Verification
The bench aims at the edges of the bounds check: an offset of exactly length-1 and exactly length, a zero-length segment, and a full-size segment whose length needs the extra bit. A design comparing with the wrong operator or truncating the length would accept one byte too many or reject a whole segment. It also stacks failures on one request to prove the cause priority, where a swapped order would report bounds instead of an unused entry, and it issues a request in the same cycle as a write to the same entry, which a design that forwards write data would answer with the new entry. Start addresses near the top of physical space check that the sum wraps instead of saturating.

// File: rtl/segx_pkg.sv
package segx_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_UNUSED = 2'd1,
    CAUSE_BOUND  = 2'd2,
    CAUSE_PERM   = 2'd3
  } fault_cause_e;

  localparam int PERM_W      = 3;
  localparam int PERM_LOAD   = 0;
  localparam int PERM_STORE  = 1;
  localparam int PERM_FETCH  = 2;

  typedef struct packed {
    logic              used;
    logic [PERM_W-1:0] perm;
  } seg_attr_t;

  function automatic logic perm_allows(input logic [PERM_W-1:0] perm, input acc_kind_e kind);
    logic allowed;
    case (kind)
      ACC_LOAD:  allowed = perm[PERM_LOAD];
      ACC_STORE: allowed = perm[PERM_STORE];
      ACC_FETCH: allowed = perm[PERM_FETCH];
      default:   allowed = 1'b0;
    endcase
    return allowed;
  endfunction

endpackage

// File: rtl/segx_table.sv
module segx_table
  import segx_pkg::*;
#(
  parameter int NSEG  = 4,
  parameter int PA_W  = 32,
  parameter int LIM_W = 31,
  localparam int IDX_W = $clog2(NSEG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [PA_W-1:0]   wr_base,
  input  logic [LIM_W-1:0]  wr_limit,
  input  seg_attr_t         wr_attr,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [PA_W-1:0]   rd_base,
  output logic [LIM_W-1:0]  rd_limit,
  output seg_attr_t         rd_attr
);

  logic [PA_W-1:0]  base_arr  [NSEG];
  logic [LIM_W-1:0] limit_arr [NSEG];
  seg_attr_t        attr_arr  [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_ent
    localparam logic [IDX_W-1:0] ENT_ID = IDX_W'(g);
    logic             ent_hit;
    logic [PA_W-1:0]  base_q;
    logic [LIM_W-1:0] limit_q;
    seg_attr_t        attr_q;

    assign ent_hit = wr_en && (wr_idx == ENT_ID);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q  <= '0;
        limit_q <= '0;
        attr_q  <= '0;
      end else if (ent_hit) begin
        base_q  <= wr_base;
        limit_q <= wr_limit;
        attr_q  <= wr_attr;
      end
    end

    assign base_arr[g]  = base_q;
    assign limit_arr[g] = limit_q;
    assign attr_arr[g]  = attr_q;
  end

  assign rd_base  = base_arr[rd_idx];
  assign rd_limit = limit_arr[rd_idx];
  assign rd_attr  = attr_arr[rd_idx];

endmodule

// File: rtl/segx_check.sv
module segx_check
  import segx_pkg::*;
#(
  parameter int OFF_W = 30,
  localparam int LIM_W = OFF_W + 1
) (
  input  logic             req_valid,
  input  logic [OFF_W-1:0] offset,
  input  logic [LIM_W-1:0] limit,
  input  seg_attr_t        attr,
  input  acc_kind_e        kind,
  output logic             in_bounds,
  output logic             perm_ok,
  output fault_cause_e     cause
);

  function automatic logic below_limit(input logic [OFF_W-1:0] off, input logic [LIM_W-1:0] lim);
    return {1'b0, off} < lim;
  endfunction

  assign in_bounds = below_limit(offset, limit);
  assign perm_ok   = perm_allows(attr.perm, kind);

  always_comb begin
    if (!req_valid)      cause = CAUSE_NONE;
    else if (!attr.used) cause = CAUSE_UNUSED;
    else if (!in_bounds) cause = CAUSE_BOUND;
    else if (!perm_ok)   cause = CAUSE_PERM;
    else                 cause = CAUSE_NONE;
  end

endmodule

// File: rtl/segx_adder.sv
module segx_adder #(
  parameter int OFF_W = 30,
  parameter int PA_W  = 32
) (
  input  logic [PA_W-1:0]  base,
  input  logic [OFF_W-1:0] offset,
  output logic [PA_W-1:0]  sum
);

  function automatic logic [PA_W-1:0] relocate(input logic [PA_W-1:0] b, input logic [OFF_W-1:0] o);
    return b + PA_W'(o);
  endfunction

  assign sum = relocate(base, offset);

endmodule

// File: rtl/segx_unit.sv
module segx_unit
  import segx_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int SEG_BITS = 2,
  parameter int PA_W     = 32,
  localparam int NSEG  = 1 << SEG_BITS,
  localparam int OFF_W = VA_W - SEG_BITS,
  localparam int LIM_W = OFF_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [SEG_BITS-1:0] wr_idx,
  input  logic [PA_W-1:0]     wr_base,
  input  logic [LIM_W-1:0]    wr_limit,
  input  logic                wr_valid,
  input  logic [2:0]          wr_perm,
  input  logic                req_valid,
  input  logic [VA_W-1:0]     req_va,
  input  logic [1:0]          req_kind,
  output logic [PA_W-1:0]     pa,
  output logic                ok,
  output logic                fault,
  output logic [1:0]          fault_cause
);

  // named internal events, observed by the bound checker
  logic [SEG_BITS-1:0] va_seg;
  logic [OFF_W-1:0]    va_off;
  logic [PA_W-1:0]     sel_base;
  logic [LIM_W-1:0]    sel_limit;
  seg_attr_t           sel_attr;
  seg_attr_t           wr_attr;
  logic                off_in_bounds;
  logic                acc_perm_ok;
  fault_cause_e        chk_cause;
  logic [PA_W-1:0]     raw_pa;

  assign va_seg  = req_va[VA_W-1 -: SEG_BITS];
  assign va_off  = req_va[OFF_W-1:0];
  assign wr_attr = '{used: wr_valid, perm: wr_perm};

  segx_table #(
    .NSEG  (NSEG),
    .PA_W  (PA_W),
    .LIM_W (LIM_W)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_base  (wr_base),
    .wr_limit (wr_limit),
    .wr_attr  (wr_attr),
    .rd_idx   (va_seg),
    .rd_base  (sel_base),
    .rd_limit (sel_limit),
    .rd_attr  (sel_attr)
  );

  segx_check #(
    .OFF_W (OFF_W)
  ) u_check (
    .req_valid (req_valid),
    .offset    (va_off),
    .limit     (sel_limit),
    .attr      (sel_attr),
    .kind      (acc_kind_e'(req_kind)),
    .in_bounds (off_in_bounds),
    .perm_ok   (acc_perm_ok),
    .cause     (chk_cause)
  );

  segx_adder #(
    .OFF_W (OFF_W),
    .PA_W  (PA_W)
  ) u_adder (
    .base   (sel_base),
    .offset (va_off),
    .sum    (raw_pa)
  );

  assign fault       = (chk_cause != CAUSE_NONE);
  assign ok          = req_valid && !fault;
  assign fault_cause = chk_cause;
  assign pa          = ok ? raw_pa : '0;

endmodule

// File: rtl/segx_unit_chk.sv
module segx_unit_chk #(
  parameter int OFF_W = 30,
  parameter int PA_W  = 32,
  localparam int LIM_W = OFF_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [1:0]       req_kind,
  input logic [OFF_W-1:0] va_off,
  input logic [PA_W-1:0]  sel_base,
  input logic [LIM_W-1:0] sel_limit,
  input logic             sel_used,
  input logic [PA_W-1:0]  pa,
  input logic             ok,
  input logic             fault,
  input logic [1:0]       fault_cause
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!ok && !fault && fault_cause == 2'd0 && pa == '0)); // R9

  AST_OK_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok && fault)); // R9

  AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (pa == '0 && fault_cause != 2'd0)); // R9

  AST_OK_NEEDS_USED: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> sel_used); // R1

  AST_UNUSED_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !sel_used) |-> fault_cause == 2'd1); // R6

  AST_OK_IN_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> ({1'b0, va_off} < sel_limit)); // R4

  AST_OK_RELOCATED: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> (pa == sel_base + PA_W'(va_off))); // R3

  AST_RSVD_KIND_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd3) |-> fault); // R5

endmodule

bind segx_unit segx_unit_chk #(
  .OFF_W (OFF_W),
  .PA_W  (PA_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_kind    (req_kind),
  .va_off      (va_off),
  .sel_base    (sel_base),
  .sel_limit   (sel_limit),
  .sel_used    (sel_attr.used),
  .pa          (pa),
  .ok          (ok),
  .fault       (fault),
  .fault_cause (fault_cause)
);

// File: tb/segx_unit_tb.sv
`timescale 1ns/1ps
module segx_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_idx = '0;
  logic [31:0] wr_base = '0;
  logic [30:0] wr_limit = '0;
  logic        wr_valid = 1'b0;
  logic [2:0]  wr_perm = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic [1:0]  req_kind = '0;
  logic [31:0] pa;
  logic        ok;
  logic        fault;
  logic [1:0]  fault_cause;

  always #10 clk = ~clk; // 50 MHz

  segx_unit u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_base(wr_base),
    .wr_limit(wr_limit), .wr_valid(wr_valid), .wr_perm(wr_perm), .req_valid(req_valid),
    .req_va(req_va), .req_kind(req_kind), .pa(pa), .ok(ok), .fault(fault),
    .fault_cause(fault_cause)
  );

  // bench-side table model
  logic [31:0] m_base [4];
  logic [30:0] m_len  [4];
  bit          m_used [4];
  logic [2:0]  m_perm [4];

  // scoreboard queues
  logic [31:0] q_pa [$];
  logic        q_ok [$];
  logic [1:0]  q_cause [$];
  string       q_tag [$];

  int  n_checks = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  task automatic expect_of(input bit rv, input int seg, input logic [29:0] off,
                           input logic [1:0] kind,
                           output logic [31:0] e_pa, output logic e_ok, output logic [1:0] e_c);
    bit allowed;
    e_pa = 32'h0; e_ok = 1'b0; e_c = 2'd0;
    allowed = (kind == 2'd0 && m_perm[seg][0]) || (kind == 2'd1 && m_perm[seg][1]) ||
              (kind == 2'd2 && m_perm[seg][2]);
    if (rv) begin
      if (!m_used[seg])                                  e_c = 2'd1;
      else if (longint'(off) >= longint'(m_len[seg]))    e_c = 2'd2;
      else if (!allowed)                                 e_c = 2'd3;
      else begin
        e_ok = 1'b1;
        e_pa = m_base[seg] + {2'b00, off};
      end
    end
  endtask

  task automatic step(input bit we, input int widx, input logic [31:0] wb, input logic [30:0] wl,
                      input bit wv, input logic [2:0] wp,
                      input bit rv, input int seg, input logic [29:0] off, input logic [1:0] kind,
                      input string tag);
    logic [31:0] e_pa; logic e_ok; logic [1:0] e_c;
    @(negedge clk);
    wr_en = we; wr_idx = 2'(widx); wr_base = wb; wr_limit = wl; wr_valid = wv; wr_perm = wp;
    req_valid = rv; req_va = {2'(seg), off}; req_kind = kind;
    expect_of(rv, seg, off, kind, e_pa, e_ok, e_c);
    q_pa.push_back(e_pa); q_ok.push_back(e_ok); q_cause.push_back(e_c); q_tag.push_back(tag);
    @(posedge clk);
    if (we) begin
      m_base[widx] = wb; m_len[widx] = wl; m_used[widx] = wv; m_perm[widx] = wp;
    end
  endtask

  task automatic req(input int seg, input logic [29:0] off, input logic [1:0] kind, input string tag);
    step(1'b0, 0, 32'h0, 31'h0, 1'b0, 3'b0, 1'b1, seg, off, kind, tag);
  endtask

  task automatic wr(input int idx, input logic [31:0] b, input logic [30:0] l, input bit v,
                    input logic [2:0] p, input string tag);
    step(1'b1, idx, b, l, v, p, 1'b0, 0, 30'h0, 2'd0, tag);
  endtask

  // monitor: compares outputs mid-cycle, away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (q_tag.size() > 0) begin
        logic [31:0] e_pa; logic e_ok; logic [1:0] e_c; string t;
        e_pa = q_pa.pop_front(); e_ok = q_ok.pop_front(); e_c = q_cause.pop_front(); t = q_tag.pop_front();
        n_checks++;
        if (pa !== e_pa || ok !== e_ok || fault !== (e_c != 2'd0) || fault_cause !== e_c) begin
          n_fail++;
          $display("FAIL %s: got pa=%h ok=%b fault=%b cause=%0d, expected pa=%h ok=%b fault=%b cause=%0d",
                   t, pa, ok, fault, fault_cause, e_pa, e_ok, (e_c != 2'd0), e_c);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog (all requirements): got hung run, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_base[i] = '0; m_len[i] = '0; m_used[i] = 1'b0; m_perm[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset leaves every entry unused
    for (int s = 0; s < 4; s++) req(s, 30'h40, 2'd0, "R1 reset unused");
    // R9: idle request gives all zeros
    step(1'b0, 0, 32'h0, 31'h0, 1'b0, 3'b0, 1'b0, 1, 30'h10, 2'd0, "R9 idle quiet");

    // R7: write seg0 and request seg0 in the same cycle -> old (unused) entry
    step(1'b1, 0, 32'h1000_0000, 31'h100, 1'b1, 3'b101, 1'b1, 0, 30'h10, 2'd0, "R7 same-cycle old entry");
    req(0, 30'h10, 2'd0, "R3 R2 seg0 load relocated");
    req(0, 30'hFF, 2'd2, "R4 last byte accepted");
    req(0, 30'h100, 2'd0, "R4 offset equal to length");
    req(0, 30'h20, 2'd1, "R5 store without permission");
    req(0, 30'h20, 2'd3, "R5 reserved kind");
    req(0, 30'h200, 2'd1, "R6 bound before perm");

    // R4: full-size segment, R8: seg0 untouched
    wr(1, 32'h2000_0000, 31'h4000_0000, 1'b1, 3'b011, "R4 write full seg");
    req(1, 30'h3FFF_FFFF, 2'd1, "R4 full-size top offset");
    req(1, 30'h0, 2'd2, "R5 fetch without permission");
    req(0, 30'h30, 2'd0, "R8 seg0 unchanged");

    // R6: unused entry beats bound; R4 zero length
    wr(2, 32'h3000_0000, 31'h10, 1'b0, 3'b111, "R6 write unused");
    req(2, 30'h100, 2'd0, "R6 unused before bound");
    wr(3, 32'h4000_0000, 31'h0, 1'b1, 3'b111, "R4 write zero length");
    req(3, 30'h0, 2'd0, "R4 zero length rejects");

    // R10: write data present with strobe low
    step(1'b0, 0, 32'hDEAD_0000, 31'h7FFF_FFFF, 1'b0, 3'b000, 1'b0, 0, 30'h0, 2'd0, "R10 strobe low idle");
    req(0, 30'h44, 2'd0, "R10 seg0 intact after strobe low");

    // R3: wrap around physical space, R2: segment select by top bits
    wr(3, 32'hFFFF_FFF0, 31'h100, 1'b1, 3'b001, "R3 write wrap seg");
    req(3, 30'h20, 2'd0, "R3 wrap modulo");
    req(1, 30'h20, 2'd0, "R2 seg1 distinct from seg3");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule